// File: doc/BRIEF.md
# Binary and Packed-BCD Add/Subtract ALU

This block is the arithmetic slice of a small processor datapath. It adds with carry or subtracts with borrow on two byte-wide operands: an accumulator value and a second operand. Two controls pick the operation and the number system. In binary mode the slice follows two's-complement rules. In decimal mode it treats each nibble as one packed-BCD digit and corrects each digit on its own.

The arithmetic is combinational. The result byte and four flags (carry, zero, overflow, negative) are captured in an output register only when the input strobe is high. A one-cycle output strobe follows each capture. In decimal mode the overflow and negative flags are always cleared. The carry input acts as "no borrow" when subtracting, and the carry output has the same meaning.

Top module: `addsub_alu`

## Requirements
- R1: In binary add (`op_sub`=0, `dec_mode`=0) the result is the low 8 bits of acc + opnd + carry_in. `flag_c` is 1 when that sum is above 255.
- R2: In binary add or subtract, `flag_v` is 1 when the two addends (acc and the possibly inverted opnd) have the same bit 7 and the result's bit 7 differs from it. That is, the signed result lies outside -128..127.
- R3: In binary subtract (`op_sub`=1) the result is acc + (opnd XOR 0xFF) + carry_in, kept to 8 bits. `flag_c` is 1 when no borrow occurred (acc - opnd - (1 - carry_in) >= 0).
- R4: In binary mode `flag_n` equals result bit 7, and `flag_z` is 1 when the result is 0x00.
- R5: In decimal add, a low-digit sum (including carry_in) above 9 is raised by 6 and carries one into the high digit. Example: 0x0A + 0x00 with carry_in 0 gives 0x10.
- R6: In decimal add, a high-digit sum above 9 is raised by 6 and sets `flag_c`. For valid BCD inputs the result is (acc + opnd + carry_in) mod 100 in BCD, and `flag_c` is 1 when that sum reaches 100.
- R7: In decimal subtract, a digit whose difference goes below zero is lowered by 6 and lends a borrow to the next digit up. The borrow into the low digit is NOT carry_in. For valid BCD the result is (acc - opnd - (1 - carry_in)) mod 100 in BCD.
- R8: In decimal subtract, `flag_c` is 1 exactly when no borrow leaves the high digit.
- R9: In decimal mode `flag_v` and `flag_n` are always 0, and `flag_z` is 1 exactly when the 8-bit result is 0x00.
- R10: Outputs are loaded only on a clock edge where `in_valid` is 1 and hold otherwise. `out_valid` is 1 for exactly the cycle after each such edge.
- R11: While `rst_n` is low, the result, all flags and `out_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Capture strobe for the current operands |
| op_sub | input | 1 | 0 = add with carry, 1 = subtract with borrow |
| dec_mode | input | 1 | 1 = packed-BCD arithmetic, 0 = binary |
| acc_in | input | 8 | Accumulator operand |
| opnd_in | input | 8 | Second operand |
| carry_in | input | 1 | Carry in (no-borrow when subtracting) |
| out_valid | output | 1 | High the cycle after a capture |
| result | output | 8 | Registered result |
| flag_c | output | 1 | Carry / no-borrow out |
| flag_z | output | 1 | Result is zero |
| flag_v | output | 1 | Signed overflow (binary only) |
| flag_n | output | 1 | Result bit 7 (binary only) |

## Verification
Every cycle, the assertions check:
- the binary sum and carry against the captured inputs;
- cleared overflow and negative after each decimal operation;
- agreement of the zero flag with the result;
- hold of the outputs without a strobe;
- the strobe timing.

Only the bench scenarios can show that the per-digit corrections give correct decimal values. They do this by comparing against a base-ten model for addition and for subtraction with borrow. The scenarios also cover the invalid-digit correction case and signed overflow at the edges of the range.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned DIGIT_W = 4;

  typedef struct packed {
    logic c;
    logic z;
    logic v;
    logic n;
  } alu_flags_t;
endpackage

// File: rtl/bin_addsub.sv
module bin_addsub #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  logic [W-1:0] b_eff;

  always_comb begin
    // subtract reuses the adder with the operand inverted
    b_eff       = sub ? ~b : b;
    {cout, sum} = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
    // same-sign inputs yielding a different-sign result
    ovf         = ~(a[W-1] ^ b_eff[W-1]) & (a[W-1] ^ sum[W-1]);
  end
endmodule

// File: rtl/bcd_addsub.sv
module bcd_addsub #(
  parameter int unsigned DIGITS = 2
) (
  input  logic [4*DIGITS-1:0] a,
  input  logic [4*DIGITS-1:0] b,
  input  logic                cin,
  input  logic                sub,
  output logic [4*DIGITS-1:0] sum,
  output logic                cout
);
  localparam int unsigned DW = 4 * DIGITS;

  logic [DIGITS:0] add_cy;
  logic [DIGITS:0] sub_bw;
  logic [DW-1:0]   add_res;
  logic [DW-1:0]   sub_res;

  assign add_cy[0] = cin;
  assign sub_bw[0] = ~cin;

  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    logic [3:0] da;
    logic [3:0] db;
    logic [5:0] s_raw;
    logic [5:0] d_raw;

    assign da = a[4*d +: 4];
    assign db = b[4*d +: 4];

    always_comb begin
      // add: correct digit sums above nine
      s_raw               = {2'b00, da} + {2'b00, db} + {5'b0, add_cy[d]};
      add_cy[d+1]         = (s_raw > 6'd9);
      add_res[4*d +: 4]   = add_cy[d+1] ? (s_raw[3:0] + 4'd6) : s_raw[3:0];
      // subtract: a negative digit difference is pulled down by six
      d_raw               = {2'b00, da} - {2'b00, db} - {5'b0, sub_bw[d]};
      sub_bw[d+1]         = d_raw[5];
      sub_res[4*d +: 4]   = sub_bw[d+1] ? (d_raw[3:0] - 4'd6) : d_raw[3:0];
    end
  end

  always_comb begin
    sum  = sub ? sub_res : add_res;
    cout = sub ? ~sub_bw[DIGITS] : add_cy[DIGITS];
  end
endmodule

// File: rtl/addsub_alu.sv
module addsub_alu #(
  parameter int unsigned DIGITS = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic                  op_sub,
  input  logic                  dec_mode,
  input  logic [4*DIGITS-1:0]   acc_in,
  input  logic [4*DIGITS-1:0]   opnd_in,
  input  logic                  carry_in,
  output logic                  out_valid,
  output logic [4*DIGITS-1:0]   result,
  output logic                  flag_c,
  output logic                  flag_z,
  output logic                  flag_v,
  output logic                  flag_n
);
  import alu_pkg::*;

  localparam int unsigned DW = alu_pkg::DIGIT_W * DIGITS;

  logic [DW-1:0] bin_sum;
  logic          bin_c;
  logic          bin_v;
  logic [DW-1:0] dec_sum;
  logic          dec_c;

  logic [DW-1:0] res_d, res_q;
  alu_flags_t    flg_d, flg_q;
  logic          vld_q;

  bin_addsub #(.W(DW)) u_bin (
    .a(acc_in), .b(opnd_in), .cin(carry_in), .sub(op_sub),
    .sum(bin_sum), .cout(bin_c), .ovf(bin_v)
  );

  bcd_addsub #(.DIGITS(DIGITS)) u_bcd (
    .a(acc_in), .b(opnd_in), .cin(carry_in), .sub(op_sub),
    .sum(dec_sum), .cout(dec_c)
  );

  // next-state selection
  always_comb begin
    if (dec_mode) begin
      res_d   = dec_sum;
      flg_d.c = dec_c;
      flg_d.v = 1'b0;
      flg_d.n = 1'b0;
    end else begin
      res_d   = bin_sum;
      flg_d.c = bin_c;
      flg_d.v = bin_v;
      flg_d.n = bin_sum[DW-1];
    end
    flg_d.z = (res_d == '0);
  end

  // output register with explicit capture enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      flg_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        res_q <= res_d;
        flg_q <= flg_d;
      end
    end
  end

  assign out_valid = vld_q;
  assign result    = res_q;
  assign flag_c    = flg_q.c;
  assign flag_z    = flg_q.z;
  assign flag_v    = flg_q.v;
  assign flag_n    = flg_q.n;

  a_r9_dec_clears_v_n: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dec_mode) |=> (!flag_v && !flag_n));

  a_r9_zero_tracks_result: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (flag_z == (result == '0)));

  a_r10_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(flag_c) && $stable(flag_z)
                   && $stable(flag_v) && $stable(flag_n)));

  a_r10_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r10_no_spurious_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R1 / R3 binary sum and carry against the captured operands
  a_r1_binary_sum: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !dec_mode) |=>
      ({flag_c, result} == ({1'b0, $past(acc_in)}
        + {1'b0, ($past(op_sub) ? ~$past(opnd_in) : $past(opnd_in))}
        + {{DW{1'b0}}, $past(carry_in)})));
endmodule

// File: tb/addsub_alu_bench.sv
module addsub_alu_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic       op_sub;
  logic       dec_mode;
  logic [7:0] acc_in;
  logic [7:0] opnd_in;
  logic       carry_in;
  logic       out_valid;
  logic [7:0] result;
  logic       flag_c, flag_z, flag_v, flag_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  addsub_alu u_addsub_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sub(op_sub),
    .dec_mode(dec_mode), .acc_in(acc_in), .opnd_in(opnd_in),
    .carry_in(carry_in), .out_valid(out_valid), .result(result),
    .flag_c(flag_c), .flag_z(flag_z), .flag_v(flag_v), .flag_n(flag_n)
  );

  // packed compare: {c,z,v,n,result}
  task automatic check(input string req, input logic [11:0] got, input logic [11:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got c%0b z%0b v%0b n%0b res=%02h, expected c%0b z%0b v%0b n%0b res=%02h",
               req, got[11], got[10], got[9], got[8], got[7:0],
               exp[11], exp[10], exp[9], exp[8], exp[7:0]);
    end
  endtask

  function automatic logic [11:0] outs();
    return {flag_c, flag_z, flag_v, flag_n, result};
  endfunction

  function automatic logic [11:0] bin_model(input int a, input int b, input int c, input bit s);
    int t, sa, sb, sr;
    logic [7:0] r;
    logic cy, ov;
    sa = (a > 127) ? a - 256 : a;
    sb = (b > 127) ? b - 256 : b;
    if (s) begin
      t  = a - b - (1 - c);
      cy = (t >= 0);
      sr = sa - sb - (1 - c);
    end else begin
      t  = a + b + c;
      cy = (t > 255);
      sr = sa + sb + c;
    end
    r  = 8'(t);
    ov = (sr > 127) || (sr < -128);
    return {cy, (r == 8'h00), ov, r[7], r};
  endfunction

  function automatic logic [11:0] dec_model(input int a, input int b, input int c, input bit s);
    int va, vb, t;
    logic cy;
    logic [7:0] r;
    va = (a / 16) * 10 + (a % 16);
    vb = (b / 16) * 10 + (b % 16);
    if (s) begin
      t  = va - vb - (1 - c);
      cy = (t >= 0);
      if (t < 0) t += 100;
    end else begin
      t  = va + vb + c;
      cy = (t >= 100);
      t  = t % 100;
    end
    r = 8'(((t / 10) << 4) | (t % 10));
    return {cy, (r == 8'h00), 1'b0, 1'b0, r};
  endfunction

  // one strobed operation; outputs sampled a full cycle later at negedge
  task automatic run_op(input bit s, input bit dm, input logic [7:0] a,
                        input logic [7:0] b, input bit c);
    @(negedge clk);
    op_sub = s; dec_mode = dm; acc_in = a; opnd_in = b; carry_in = c;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 0; op_sub = 0; dec_mode = 0;
    acc_in = 0; opnd_in = 0; carry_in = 0;
    repeat (3) @(negedge clk);
    check("R11 reset outputs", outs(), 12'h000);
    checks++;
    if (out_valid !== 1'b0) begin fails++; $display("FAIL R11 out_valid got %0b expected 0", out_valid); end
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_binary_add();
    run_op(0, 0, 8'h01, 8'h01, 0); check("R1 1+1", outs(), bin_model(1, 1, 0, 0));
    run_op(0, 0, 8'hFF, 8'h01, 0); check("R1 R4 carry and zero", outs(), 12'hC00);
    run_op(0, 0, 8'h7F, 8'h00, 1); check("R2 positive overflow", outs(), {4'b0011, 8'h80});
    run_op(0, 0, 8'h80, 8'hFF, 0); check("R2 negative overflow", outs(), {4'b1010, 8'h7F});
    for (int a = 0; a < 256; a += 17)
      for (int b = 0; b < 256; b += 13) begin
        run_op(0, 0, 8'(a), 8'(b), a[0]);
        check("R1 R2 R4 add sweep", outs(), bin_model(a, b, a[0], 0));
      end
  endtask

  task automatic t_binary_sub();
    run_op(1, 0, 8'h05, 8'h03, 1); check("R3 5-3", outs(), {4'b1000, 8'h02});
    run_op(1, 0, 8'h00, 8'h01, 1); check("R3 R4 borrow", outs(), {4'b0001, 8'hFF});
    run_op(1, 0, 8'h80, 8'h01, 1); check("R2 R3 sub overflow", outs(), {4'b1010, 8'h7F});
    for (int a = 0; a < 256; a += 19)
      for (int b = 0; b < 256; b += 11) begin
        run_op(1, 0, 8'(a), 8'(b), b[0]);
        check("R2 R3 R4 sub sweep", outs(), bin_model(a, b, b[0], 1));
      end
  endtask

  task automatic t_decimal_add();
    run_op(0, 1, 8'h0A, 8'h00, 0); check("R5 invalid low digit", outs(), {4'b0000, 8'h10});
    run_op(0, 1, 8'h09, 8'h01, 0); check("R5 low carry", outs(), {4'b0000, 8'h10});
    run_op(0, 1, 8'h99, 8'h00, 1); check("R6 R9 wrap to zero", outs(), {4'b1100, 8'h00});
    run_op(0, 1, 8'h58, 8'h46, 1); check("R6 carry out", outs(), {4'b1000, 8'h05});
    for (int a = 0; a < 100; a += 7)
      for (int b = 0; b < 100; b += 3) begin
        logic [7:0] pa, pb;
        pa = 8'(((a / 10) << 4) | (a % 10));
        pb = 8'(((b / 10) << 4) | (b % 10));
        run_op(0, 1, pa, pb, b[0]);
        check("R5 R6 R9 add sweep", outs(), dec_model(pa, pb, b[0], 0));
      end
  endtask

  task automatic t_decimal_sub();
    run_op(1, 1, 8'h10, 8'h01, 1); check("R7 low borrow", outs(), {4'b1000, 8'h09});
    run_op(1, 1, 8'h00, 8'h01, 1); check("R7 R8 borrow out", outs(), {4'b0000, 8'h99});
    run_op(1, 1, 8'h46, 8'h12, 0); check("R7 borrow in", outs(), {4'b1000, 8'h33});
    run_op(1, 1, 8'h42, 8'h42, 1); check("R8 R9 equal", outs(), {4'b1100, 8'h00});
    for (int a = 0; a < 100; a += 3)
      for (int b = 0; b < 100; b += 7) begin
        logic [7:0] pa, pb;
        pa = 8'(((a / 10) << 4) | (a % 10));
        pb = 8'(((b / 10) << 4) | (b % 10));
        run_op(1, 1, pa, pb, a[0]);
        check("R7 R8 R9 sub sweep", outs(), dec_model(pa, pb, a[0], 1));
      end
  endtask

  task automatic t_hold();
    logic [11:0] held;
    run_op(0, 0, 8'h12, 8'h34, 0);
    held = outs();
    check("R10 captured", held, bin_model(18, 52, 0, 0));
    op_sub = 1; dec_mode = 1; acc_in = 8'h00; opnd_in = 8'h77; carry_in = 1;
    repeat (3) @(negedge clk);
    check("R10 hold without strobe", outs(), held);
    checks++;
    if (out_valid !== 1'b0) begin fails++; $display("FAIL R10 out_valid got %0b expected 0", out_valid); end
    @(negedge clk); in_valid = 1'b1;
    @(negedge clk); in_valid = 1'b0;
    checks++;
    if (out_valid !== 1'b1) begin fails++; $display("FAIL R10 out_valid got %0b expected 1", out_valid); end
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin fails++; $display("FAIL R10 strobe width got %0b expected 0", out_valid); end
  endtask

  initial begin
    t_reset();
    t_binary_add();
    t_binary_sub();
    t_decimal_add();
    t_decimal_sub();
    t_hold();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule